// File: doc/BRIEF.md
# Ternary Successor-Rail Checker Tree

This block gathers the check digits of several concurrently tested ternary logic blocks and reduces them to one verdict. Every monitored block presents a pair of ternary digits (a low rail and a high rail). The pair is healthy when the high digit equals the low digit plus one, modulo 3. Two healthy pairs merge into one healthy pair. Any unhealthy pair yields a merged pair that is never in successor relation.

A merging cell has two independent comparison elements. The low element looks only at the first incoming pair. It applies a +1 shift to a constant zero when that pair is healthy, so it produces 1, and it passes 0 otherwise. The high element looks only at the second pair and applies a +2 shift, so it produces 2 when the pair is healthy and 0 otherwise. Because the merged pair keeps the same successor format, cells stack into a binary tree. A final comparison at the root raises a single fault flag. Each digit travels as a 2-bit code; the code 3 is not a ternary value and always counts as unhealthy.

The whole path is combinational. When the pair count is not a power of two, the tree is padded with constant healthy pairs (0,1).

Top module: `tern_rail_tree`

## Requirements
- R1: The low element of every merging cell outputs 1 when its pair's high digit equals (low digit + 1) mod 3 and both digits are valid, and outputs 0 otherwise; at the root this appears on `outLo`.
- R2: The high element of every merging cell outputs 2 when its pair is healthy by the same rule, and outputs 0 otherwise; at the root this appears on `outHi`.
- R3: When every input pair is healthy, `outLo` = 1, `outHi` = 2 and `fault` = 0.
- R4: When at least one input pair is unhealthy, `outHi` is never (`outLo` + 1) mod 3; `outLo` is always 0 or 1 and `outHi` is always 0 or 2.
- R5: `outLo` depends only on the pairs in the lower half of the padded leaf range, and `outHi` depends only on the pairs in the upper half (pair index >= half the padded count).
- R6: A digit code of 3 makes its pair unhealthy and raises `fault`.
- R7: With a pair count that is not a power of two, the padding positions count as healthy, so only real pairs decide the outputs.
- R8: `fault` is 1 exactly when the final pair (`outLo`, `outHi`) does not satisfy the successor relation with valid digits.
- R9: Input pair i occupies `inPairs[4i+3:4i]`, with the low digit in bits [4i+1:4i] and the high digit in bits [4i+3:4i+2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inPairs | input | 4*NUM_PAIRS | Packed check-digit pairs from the monitored blocks |
| outLo | output | 2 | Low rail of the merged pair (cascadable) |
| outHi | output | 2 | High rail of the merged pair (cascadable) |
| fault | output | 1 | High when the merged pair is not a successor pair |

## Verification
The bench builds two copies of the block. The first has four pairs, a two-level tree with no padding. The second has three pairs, so one padded leaf sits in the upper half. Both copies are driven through every possible input code, including the invalid code 3 in every digit position: 65,536 patterns for four pairs and 4,096 for three. Each pattern is checked against a model that classifies each pair on its own. This covers every mix of healthy, unhealthy and invalid pairs, confirms that the two rails separate by subtree, and confirms that padding never masks a real fault.

// File: rtl/tern_rail_pkg.sv
package tern_rail_pkg;

  typedef logic [1:0] trit_t;

  // high digit in upper bits so a packed pair matches the port layout
  typedef struct packed {
    trit_t hi;
    trit_t lo;
  } railPair_t;

  // strobes from the verdict logic to the thin top
  typedef struct packed {
    logic succOk;
    logic codeBad;
  } railStatus_t;

  localparam trit_t TRIT_ZERO = 2'd0;
  localparam trit_t TRIT_BAD  = 2'd3;

  function automatic logic tritValid(trit_t t);
    return t != TRIT_BAD;
  endfunction

  // modular shift of a valid trit by a small amount
  function automatic trit_t tritShift(trit_t t, int unsigned amt);
    int unsigned s;
    s = (int'(t) + amt) % 3;
    return s[1:0];
  endfunction

  function automatic logic isSuccPair(trit_t lo, trit_t hi);
    return tritValid(lo) && tritValid(hi) && (hi == tritShift(lo, 1));
  endfunction

endpackage

// File: rtl/succ_element.sv
module succ_element
  import tern_rail_pkg::*;
#(
  parameter int unsigned SHIFT = 1
) (
  input  trit_t ctlA,
  input  trit_t ctlB,
  input  trit_t target,
  output trit_t result
);

  logic pairHealthy;

  always_comb begin
    pairHealthy = isSuccPair(ctlA, ctlB);
    result      = pairHealthy ? tritShift(target, SHIFT) : target;
  end

endmodule

// File: rtl/rail_checker.sv
module rail_checker
  import tern_rail_pkg::*;
(
  input  railPair_t pairA,
  input  railPair_t pairB,
  output railPair_t merged
);

  // two separate elements, each with its own constant-zero target
  succ_element #(.SHIFT(1)) u_lowElem (
    .ctlA   (pairA.lo),
    .ctlB   (pairA.hi),
    .target (TRIT_ZERO),
    .result (merged.lo)
  );

  succ_element #(.SHIFT(2)) u_highElem (
    .ctlA   (pairB.lo),
    .ctlB   (pairB.hi),
    .target (TRIT_ZERO),
    .result (merged.hi)
  );

endmodule

// File: rtl/rail_tree.sv
module rail_tree
  import tern_rail_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4
) (
  input  railPair_t [NUM_PAIRS-1:0] leaves,
  output railPair_t                 root
);

  localparam int unsigned LEVELS = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 0;
  localparam int unsigned PADDED = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * PADDED - 1;

  // heap layout: node k has children 2k+1 and 2k+2, leaves at the end
  railPair_t nodes [NODES];

  genvar i;
  generate
    for (i = 0; i < PADDED; i++) begin : g_leaf
      if (i < NUM_PAIRS) begin : g_real
        assign nodes[PADDED-1+i] = leaves[i];
      end else begin : g_pad
        assign nodes[PADDED-1+i] = '{hi: 2'd1, lo: 2'd0};
      end
    end

    for (i = 0; i < PADDED - 1; i++) begin : g_node
      rail_checker u_cell (
        .pairA  (nodes[2*i+1]),
        .pairB  (nodes[2*i+2]),
        .merged (nodes[i])
      );
    end
  endgenerate

  assign root = nodes[0];

endmodule

// File: rtl/rail_verdict.sv
module rail_verdict
  import tern_rail_pkg::*;
(
  input  railPair_t   finalPair,
  output railStatus_t status
);

  always_comb begin
    status.codeBad = !tritValid(finalPair.lo) || !tritValid(finalPair.hi);
    status.succOk  = (finalPair.hi == tritShift(finalPair.lo, 1));
  end

endmodule

// File: rtl/tern_rail_tree.sv
module tern_rail_tree
  import tern_rail_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4
) (
  input  logic [4*NUM_PAIRS-1:0] inPairs,
  output logic [1:0]             outLo,
  output logic [1:0]             outHi,
  output logic                   fault
);

  railPair_t [NUM_PAIRS-1:0] leafVec;
  railPair_t                 rootPair;
  railStatus_t               status;

  assign leafVec = inPairs;

  rail_tree #(.NUM_PAIRS(NUM_PAIRS)) u_tree (
    .leaves (leafVec),
    .root   (rootPair)
  );

  rail_verdict u_verdict (
    .finalPair (rootPair),
    .status    (status)
  );

  assign outLo = rootPair.lo;
  assign outHi = rootPair.hi;
  assign fault = status.codeBad || !status.succOk;

endmodule

// File: rtl/tern_rail_tree_sva.sv
module tern_rail_tree_sva #(
  parameter int unsigned NUM_PAIRS = 4
) (
  input logic [4*NUM_PAIRS-1:0] inPairs,
  input logic [1:0]             outLo,
  input logic [1:0]             outHi,
  input logic                   fault
);

  function automatic logic [1:0] nextTrit(logic [1:0] t);
    return (t == 2'd2) ? 2'd0 : t + 2'd1;
  endfunction

  logic allGood;
  logic anyInvalid;
  logic outSucc;

  always_comb begin
    allGood    = 1'b1;
    anyInvalid = 1'b0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (inPairs[4*p +: 2] == 2'd3 || inPairs[4*p+2 +: 2] == 2'd3) begin
        anyInvalid = 1'b1;
        allGood    = 1'b0;
      end else if (inPairs[4*p+2 +: 2] != nextTrit(inPairs[4*p +: 2])) begin
        allGood = 1'b0;
      end
    end
    outSucc = (outLo != 2'd3) && (outHi != 2'd3) && (outHi == nextTrit(outLo));

    if (NUM_PAIRS >= 2) begin
      assert_rail_range_R4: assert ((outLo == 2'd0 || outLo == 2'd1) &&
                                    (outHi == 2'd0 || outHi == 2'd2));
      assert_no_false_succ_R4: assert (allGood || !outSucc);
    end
    assert_all_good_R3: assert (!allGood || (outLo == 2'd1 && outHi == 2'd2 && !fault));
    assert_invalid_code_R6: assert (!anyInvalid || fault);
    assert_flag_match_R8: assert (fault == !outSucc);
  end

endmodule

bind tern_rail_tree tern_rail_tree_sva #(.NUM_PAIRS(NUM_PAIRS)) u_sva (
  .inPairs (inPairs),
  .outLo   (outLo),
  .outHi   (outHi),
  .fault   (fault)
);

// File: tb/tern_rail_tree_bench.sv
`timescale 1ns/1ps
module tern_rail_tree_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int  total = 0;
  int  bad = 0;
  bit  doneFlag = 1'b0;

  logic [15:0] pairs4 = '0;
  logic [11:0] pairs3 = '0;
  logic [1:0]  lo4, hi4, lo3, hi3;
  logic        flt4, flt3;

  tern_rail_tree #(.NUM_PAIRS(4)) u_tern_rail_tree (
    .inPairs (pairs4), .outLo (lo4), .outHi (hi4), .fault (flt4)
  );

  tern_rail_tree #(.NUM_PAIRS(3)) u_tern_rail_tree_p3 (
    .inPairs (pairs3), .outLo (lo3), .outHi (hi3), .fault (flt3)
  );

  typedef struct {
    logic [1:0] lo;
    logic [1:0] hi;
    logic       flt;
    logic       invalid;
  } expect_t;

  expect_t q4[$];
  expect_t q3[$];

  // R9 layout: low digit in [1:0], high digit in [3:2]; R6: code 3 is unhealthy
  function automatic bit pairGood(logic [3:0] p);
    logic [1:0] x, y;
    x = p[1:0];
    y = p[3:2];
    if (x == 2'd3 || y == 2'd3) return 1'b0;
    return (x == 2'd2) ? (y == 2'd0) : (y == x + 2'd1);
  endfunction

  function automatic bit hasInvalid(logic [15:0] v, int n);
    for (int k = 0; k < 2 * n; k++)
      if (v[2*k +: 2] == 2'd3) return 1'b1;
    return 1'b0;
  endfunction

  function automatic expect_t makeExp(bit lowOk, bit highOk, bit inv);
    expect_t e;
    e.lo      = lowOk  ? 2'd1 : 2'd0;
    e.hi      = highOk ? 2'd2 : 2'd0;
    e.flt     = !(lowOk && highOk);
    e.invalid = inv;
    return e;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver
  initial begin
    for (int v = 0; v < 65536; v++) begin
      @(posedge clk);
      #1;
      pairs4 = v[15:0];
      q4.push_back(makeExp(pairGood(pairs4[3:0]) && pairGood(pairs4[7:4]),
                           pairGood(pairs4[11:8]) && pairGood(pairs4[15:12]),
                           hasInvalid(pairs4, 4)));
    end
    for (int v = 0; v < 4096; v++) begin
      @(posedge clk);
      #1;
      pairs3 = v[11:0];
      // padded fourth leaf counts healthy (R7)
      q3.push_back(makeExp(pairGood(pairs3[3:0]) && pairGood(pairs3[7:4]),
                           pairGood(pairs3[11:8]),
                           hasInvalid({4'd0, pairs3}, 3)));
    end
    repeat (3) @(posedge clk);
    doneFlag = 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (q4.size() > 0) begin
      expect_t e;
      e = q4.pop_front();
      check("R1 R5 low rail", int'(lo4), int'(e.lo));
      check("R2 R5 high rail", int'(hi4), int'(e.hi));
      if (e.invalid) check("R6 fault on invalid code", int'(flt4), 1);
      else if (!e.flt) check("R3 all healthy fault", int'(flt4), 0);
      else check("R8 fault flag", int'(flt4), int'(e.flt));
      if (e.flt)
        check("R4 no successor on failure",
              int'(hi4 == ((lo4 == 2'd2) ? 2'd0 : lo4 + 2'd1)), 0);
    end
    if (q3.size() > 0) begin
      expect_t e;
      e = q3.pop_front();
      check("R7 padded low rail", int'(lo3), int'(e.lo));
      check("R7 padded high rail", int'(hi3), int'(e.hi));
      check("R8 padded fault flag", int'(flt3), int'(e.flt));
    end
  end

  // watchdog and summary
  initial begin
    fork
      begin
        wait (doneFlag);
      end
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule